// File: doc/BRIEF.md
# Lazy Condition Flag Evaluator

This block works out the four integer condition flags (negative, zero, overflow, carry) some time after the operation that produced them. It does not look at a live adder. The execution side stores three things: a tag naming the kind of operation, the 32-bit result it wrote, and one 32-bit operand. When a later instruction needs the flags, the core raises a request strobe and the evaluator rebuilds the flags from those saved words.

The operation kinds are logic, add, subtract, byte compare, word compare, add with extend, subtract with extend, shift and a direct pass-through of a flag word. For the extended kinds, multi-word arithmetic must keep Z across the words. A sticky-zero enable combines the new Z with the Z kept from the previous word. An unknown tag raises an error strobe and leaves the flags as they were.

The output is registered. It appears, with a one-cycle valid pulse, on the clock edge after the request.

Top module: `ccf_lazy_eval`

## Requirements
- R1: For every computed tag (all except pass-through), Z is set when the evaluated result bits are all zero. Otherwise N copies the top evaluated bit. N and Z are never both set for a computed tag.
- R2: For the add tag (2), C is set when result < operand, unsigned. V is the top bit of (operand ^ result) & ~((result - operand) ^ operand).
- R3: For the subtract tag (3), the minuend is rebuilt as m = result + operand. C is set when m < operand, unsigned. V is the top bit of (m ^ result) & (m ^ operand).
- R4: Byte compare (tag 4) and word compare (tag 5) apply the rule of R3 to only the low 8 or 16 bits, with bit 7 or bit 15 as the sign bit. Upper bits have no effect.
- R5: For the add-with-extend tag (6), C is set when result <= operand, unsigned. V uses the formula of R2 with (result - operand - 1) in place of (result - operand).
- R6: For the subtract-with-extend tag (7), m = result + operand + 1. C is set when m <= operand, unsigned. V is the top bit of (m ^ result) & (m ^ operand).
- R7: For the shift tag (8), N and Z follow R1, C is set when the saved operand (the carry-out word) is nonzero, and V is 0.
- R8: For the logic tag (1), N and Z follow R1, and V and C are 0.
- R9: The flag vector is {N,Z,V,C} on bits 3..0. The pass-through tag (0) copies result bits 3..0 to the flags unchanged.
- R10: When the sticky enable is high on a computed tag, the output Z is the new Z ANDed with the previous Z input. The pass-through tag ignores the sticky enable.
- R11: Tags 9 to 15 are unknown. A request with one raises the error output for one cycle and leaves the flag output unchanged.
- R12: Reset clears the flags, valid and error outputs. A request updates the flags and pulses valid for one cycle on the next clock edge. With no request, valid stays low and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Evaluate request strobe |
| tag_i | input | 4 | Saved operation tag |
| res_i | input | 32 | Saved result word |
| opnd_i | input | 32 | Saved operand word |
| prev_z_i | input | 1 | Z kept from the previous word |
| sticky_z_i | input | 1 | Sticky-zero enable |
| flags_o | output | 4 | Flags {N,Z,V,C} |
| valid_o | output | 1 | One-cycle pulse when flags_o has been refreshed |
| err_o | output | 1 | One-cycle pulse for an unknown tag |

## Verification
The hardest cases to reach are the narrow compares and the extended forms. For a narrow compare, the upper result bits would give a different answer if the block wrongly looked at them. For the extended forms, the extra one in the carry-in turns a strict comparison into a non-strict one exactly at equality. The stimulus table therefore has byte and word compare rows whose upper bits are filled with contradicting values. It also has extend rows where the rebuilt minuend equals the operand, and rows that pair a zero result with a cleared previous Z. Directed tests then send unknown tags straight after a known result, to show the held flags come through unchanged.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    localparam int FLAG_W = 4;

    typedef enum logic [3:0] {
        CC_PASS  = 4'd0,
        CC_LOGIC = 4'd1,
        CC_ADD   = 4'd2,
        CC_SUB   = 4'd3,
        CC_CMPB  = 4'd4,
        CC_CMPW  = 4'd5,
        CC_ADDX  = 4'd6,
        CC_SUBX  = 4'd7,
        CC_SHIFT = 4'd8
    } cc_tag_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

    localparam cc_flags_t FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

    function automatic logic tag_known(input logic [3:0] t);
        return t <= 4'(CC_SHIFT);
    endfunction

endpackage

// File: rtl/ccf_nz_detect.sv
module ccf_nz_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    output logic         n_o,
    output logic         z_o
);
    always_comb begin
        z_o = (val_i == '0);
        n_o = val_i[W-1];
    end
endmodule

// File: rtl/ccf_sub_flags.sv
module ccf_sub_flags
    import ccf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res_i,
    input  logic [W-1:0] opnd_i,
    input  logic         cin_i,
    output cc_flags_t    flags_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] minuend;
    logic [W-1:0] ovf_vec;
    logic         n_w;
    logic         z_w;

    ccf_nz_detect #(.W(W)) u_nz (
        .val_i (res_i),
        .n_o   (n_w),
        .z_o   (z_w)
    );

    always_comb begin
        minuend   = res_i + opnd_i + (cin_i ? ONE : '0);
        ovf_vec   = (minuend ^ res_i) & (minuend ^ opnd_i);
        flags_o.n = n_w;
        flags_o.z = z_w;
        flags_o.v = ovf_vec[W-1];
        flags_o.c = cin_i ? (minuend <= opnd_i) : (minuend < opnd_i);
    end
endmodule

// File: rtl/ccf_add_flags.sv
module ccf_add_flags
    import ccf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res_i,
    input  logic [W-1:0] opnd_i,
    input  logic         cin_i,
    output cc_flags_t    flags_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] addend;
    logic [W-1:0] ovf_vec;
    logic         n_w;
    logic         z_w;

    ccf_nz_detect #(.W(W)) u_nz (
        .val_i (res_i),
        .n_o   (n_w),
        .z_o   (z_w)
    );

    always_comb begin
        addend    = res_i - opnd_i - (cin_i ? ONE : '0);
        ovf_vec   = (opnd_i ^ res_i) & ~(addend ^ opnd_i);
        flags_o.n = n_w;
        flags_o.z = z_w;
        flags_o.v = ovf_vec[W-1];
        flags_o.c = cin_i ? (res_i <= opnd_i) : (res_i < opnd_i);
    end
endmodule

// File: rtl/ccf_lazy_eval.sv
module ccf_lazy_eval
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              prev_z_i,
    input  logic              sticky_z_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int NARROW_N = 2;

    function automatic int narrow_w(input int idx);
        return (idx == 0) ? 8 : 16;
    endfunction

    cc_tag_e   tag;
    logic      known;
    cc_flags_t add_f;
    cc_flags_t sub_f;
    cc_flags_t cmp_f [NARROW_N];
    cc_flags_t nxt_f;
    cc_flags_t flags_q;
    logic      full_n;
    logic      full_z;
    logic      valid_q;
    logic      err_q;

    assign tag   = cc_tag_e'(tag_i);
    assign known = tag_known(tag_i);

    ccf_nz_detect #(.W(DATA_W)) u_nz_full (
        .val_i (res_i),
        .n_o   (full_n),
        .z_o   (full_z)
    );

    ccf_add_flags #(.W(DATA_W)) u_add (
        .res_i   (res_i),
        .opnd_i  (opnd_i),
        .cin_i   (tag == CC_ADDX),
        .flags_o (add_f)
    );

    ccf_sub_flags #(.W(DATA_W)) u_sub (
        .res_i   (res_i),
        .opnd_i  (opnd_i),
        .cin_i   (tag == CC_SUBX),
        .flags_o (sub_f)
    );

    for (genvar g = 0; g < NARROW_N; g++) begin : g_cmp
        localparam int NW = narrow_w(g);
        ccf_sub_flags #(.W(NW)) u_cmp (
            .res_i   (res_i[NW-1:0]),
            .opnd_i  (opnd_i[NW-1:0]),
            .cin_i   (1'b0),
            .flags_o (cmp_f[g])
        );
    end

    always_comb begin
        nxt_f = FLAGS_CLEAR;
        unique case (tag)
            CC_PASS:           nxt_f = cc_flags_t'(res_i[FLAG_W-1:0]);
            CC_LOGIC: begin
                nxt_f.n = full_n;
                nxt_f.z = full_z;
            end
            CC_ADD, CC_ADDX:   nxt_f = add_f;
            CC_SUB, CC_SUBX:   nxt_f = sub_f;
            CC_CMPB:           nxt_f = cmp_f[0];
            CC_CMPW:           nxt_f = cmp_f[1];
            CC_SHIFT: begin
                nxt_f.n = full_n;
                nxt_f.z = full_z;
                nxt_f.c = (opnd_i != '0);
            end
            default:           nxt_f = flags_q;
        endcase
        if (sticky_z_i && tag != CC_PASS) begin
            nxt_f.z = nxt_f.z & prev_z_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_CLEAR;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= req_i;
            err_q   <= req_i & ~known;
            if (req_i && known) begin
                flags_q <= nxt_f;
            end
        end
    end

    assign flags_o = flags_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;

    assert_valid_follows_req_R12: assert property (@(posedge clk) disable iff (rst)
        req_i |=> valid_o);

    assert_no_spurious_valid_R12: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (!valid_o && $stable(flags_o)));

    assert_unknown_raises_err_R11: assert property (@(posedge clk) disable iff (rst)
        (req_i && !known) |=> err_o);

    assert_err_holds_flags_R11: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $stable(flags_o));

    assert_nz_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !err_o && $past(tag_i) != 4'(CC_PASS)) |-> !(flags_o[3] && flags_o[2]));

    assert_shift_v_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(tag_i) == 4'(CC_SHIFT)) |-> !flags_o[1]);

    assert_logic_vc_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(tag_i) == 4'(CC_LOGIC)) |-> (flags_o[1:0] == 2'b00));

    assert_sticky_clears_z_R10: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !err_o && $past(sticky_z_i) && !$past(prev_z_i)
         && $past(tag_i) != 4'(CC_PASS)) |-> !flags_o[2]);

endmodule

// File: tb/tb_ccf_lazy_eval.sv
module tb_ccf_lazy_eval;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 30;
    localparam int WATCHDOG   = 5000;

    // row: {req_no[3:0], tag[3:0], res[31:0], opnd[31:0], prev_z, sticky, expect NZVC[3:0]}
    localparam logic [77:0] VEC [N_VEC] = '{
        {4'd8,  4'd1, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 4'b0100}, // R8 R1 zero
        {4'd8,  4'd1, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0, 4'b1000}, // R8 negative
        {4'd8,  4'd1, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'b0000}, // R8 operand ignored
        {4'd2,  4'd2, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b0, 4'b1010}, // R2 signed ovf
        {4'd2,  4'd2, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0, 4'b0101}, // R2 wrap carry
        {4'd2,  4'd2, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b0, 4'b0111}, // R2 carry+ovf
        {4'd3,  4'd3, 32'h0000_0002, 32'h0000_0003, 1'b0, 1'b0, 4'b0000}, // R3 plain
        {4'd3,  4'd3, 32'hFFFF_FFFE, 32'h0000_0005, 1'b0, 1'b0, 4'b1001}, // R3 borrow
        {4'd3,  4'd3, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 4'b0010}, // R3 ovf
        {4'd3,  4'd3, 32'h0000_0000, 32'h0000_1234, 1'b0, 1'b0, 4'b0100}, // R3 equal
        {4'd4,  4'd4, 32'hABCD_EF00, 32'h0000_0012, 1'b0, 1'b0, 4'b0100}, // R4 byte equal
        {4'd4,  4'd4, 32'h1234_567F, 32'hFFFF_FF01, 1'b0, 1'b0, 4'b0010}, // R4 byte ovf
        {4'd4,  4'd4, 32'h0000_00FF, 32'h0000_0002, 1'b0, 1'b0, 4'b1001}, // R4 byte borrow
        {4'd4,  4'd5, 32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b0, 4'b1001}, // R4 word borrow
        {4'd4,  4'd5, 32'hABCD_7FFF, 32'h0000_0001, 1'b0, 1'b0, 4'b0010}, // R4 word ovf
        {4'd5,  4'd6, 32'h0000_0009, 32'h0000_0003, 1'b0, 1'b0, 4'b0000}, // R5 plain
        {4'd5,  4'd6, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, 4'b0101}, // R5 equal carry, Z kept
        {4'd10, 4'd6, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, 4'b0001}, // R10 Z cleared
        {4'd5,  4'd6, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0, 4'b1010}, // R5 ovf
        {4'd6,  4'd7, 32'h0000_0001, 32'h0000_0003, 1'b0, 1'b0, 4'b0000}, // R6 plain
        {4'd6,  4'd7, 32'hFFFF_FFFF, 32'h0000_0003, 1'b0, 1'b0, 4'b1001}, // R6 equal borrow
        {4'd6,  4'd7, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'b0101}, // R6 wrap, Z kept
        {4'd6,  4'd7, 32'h7FFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, 4'b0010}, // R6 ovf
        {4'd7,  4'd8, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0, 4'b0101}, // R7 zero+carry
        {4'd7,  4'd8, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0, 4'b1000}, // R7 negative
        {4'd7,  4'd8, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b0, 4'b0000}, // R7 clear
        {4'd10, 4'd3, 32'h0000_0000, 32'h0000_1234, 1'b0, 1'b1, 4'b0000}, // R10 on subtract
        {4'd9,  4'd0, 32'hFFFF_FFF6, 32'h0000_0000, 1'b0, 1'b0, 4'b0110}, // R9 low bits
        {4'd9,  4'd0, 32'h0000_000F, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'b1111}, // R9 R10 sticky ignored
        {4'd1,  4'd3, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0, 4'b1000}  // R1 negative only
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [3:0]  tag;
    logic [31:0] res;
    logic [31:0] opnd;
    logic        prev_z;
    logic        sticky;
    logic [3:0]  flags;
    logic        valid;
    logic        err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccf_lazy_eval dut (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .tag_i      (tag),
        .res_i      (res),
        .opnd_i     (opnd),
        .prev_z_i   (prev_z),
        .sticky_z_i (sticky),
        .flags_o    (flags),
        .valid_o    (valid),
        .err_o      (err)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] t, input logic [31:0] r, input logic [31:0] o,
                         input logic pz, input logic st);
        @(negedge clk);
        req = 1'b1; tag = t; res = r; opnd = o; prev_z = pz; sticky = st;
        @(negedge clk);
        req = 1'b0; tag = 4'd0; res = '0; opnd = '0; prev_z = 1'b0; sticky = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = 1'b0; tag = '0; res = '0; opnd = '0; prev_z = 1'b0; sticky = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 reset flags", 32'(flags), 32'h0);
        check("R12 reset valid", 32'(valid), 32'h0);
        check("R12 reset err",   32'(err),   32'h0);
        rst = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            logic [77:0] row;
            row = VEC[i];
            issue(row[73:70], row[69:38], row[37:6], row[5], row[4]);
            check($sformatf("R%0d vector %0d", row[77:74], i), 32'(flags), 32'(row[3:0]));
            check("R12 valid pulse", 32'(valid), 32'h1);
        end

        // R12: idle cycle, valid low and flags held (last row gave 4'b1000)
        @(negedge clk);
        check("R12 idle valid", 32'(valid), 32'h0);
        check("R12 idle hold",  32'(flags), 32'h8);

        // R11: unknown tags after a known result
        issue(4'd0, 32'h0000_0005, 32'h0, 1'b0, 1'b0);
        check("R9 setup", 32'(flags), 32'h5);
        issue(4'd9, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0);
        check("R11 err tag9",   32'(err),   32'h1);
        check("R11 hold tag9",  32'(flags), 32'h5);
        issue(4'd15, 32'h8000_0000, 32'h0, 1'b1, 1'b1);
        check("R11 err tag15",  32'(err),   32'h1);
        check("R11 hold tag15", 32'(flags), 32'h5);
        issue(4'd1, 32'h0, 32'h0, 1'b0, 1'b0);
        check("R11 err clears", 32'(err),   32'h0);
        check("R8 after err",   32'(flags), 32'h4);

        // R12: reset in mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R12 mid reset flags", 32'(flags), 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule